// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a processor and runs instruction loops in hardware. A block-loop command starts a loop. The command carries an iteration count and the address of the last instruction in the loop body. The body starts at the address that follows the command. Each cycle the block compares the current fetch address against the loop's last address. When that address is fetched and iterations remain, the block overrides the next fetch address in the same cycle and sends it back to the body start. Looping therefore costs no cycles, and instructions take no extra cycles on the first pass or outside any loop.

A repeat command runs the single instruction that follows it a given number of times by holding the fetch address on that instruction. A repeat may run inside an active block loop, including on the block loop's last instruction. Interrupts can enter while a block loop is active. During service the loop leaves the fetch stream alone but keeps its state, and it continues when service returns. A repeat cannot be interrupted, so the block raises an interrupt lock while one runs. Block loops nest one level deep: a second block start while one is running is refused and flagged.

Top module: `hwl_ctrl`

## Requirements
- R1: After reset, redirect_o, blk_active_o, rep_active_o, isr_lock_o and nest_err_o are all 0.
- R2: A block start with count N>=1 accepted at fetch address P with last address L runs the addresses P+1..L exactly N times. On each fetch of L except the final pass, redirect_o is 1 in that same cycle with redirect_pc_o = P+1. No other cycle redirects, so the whole loop takes N*(L-P) fetch cycles.
- R3: Each command takes its count from cnt_reg_i when its source bit is 1 and from its own immediate input when the bit is 0.
- R4: A block start with count 0 redirects in the same cycle to L+1 and leaves no loop active.
- R5: On the final pass the fetch of L does not redirect, and blk_active_o is 0 from the next cycle.
- R6: A block start while a block loop is active drives nest_err_o to 1 in that cycle and leaves the running loop's addresses and count unchanged.
- R7: A repeat start with count M>=1 at fetch address Q fetches Q+1 exactly M times. Each fetch of Q+1 except the last redirects to Q+1. rep_active_o is 1 from the cycle after the start until the last fetch of Q+1 has completed.
- R8: A repeat start with count 0 redirects in the same cycle to Q+2.
- R9: A repeat on the last instruction of a block loop holds that instruction for its full count on every pass. The block loop redirects only on the final repeated fetch of each pass.
- R10: From the cycle after isr_enter_i until the matching isr_exit_i, fetching L produces no block redirect and leaves the loop state unchanged. After exit the loop completes its remaining iterations.
- R11: isr_lock_o is 1 whenever a repeat is active.
- R12: The interrupt nesting depth counts enters and exits. An exit at depth 0 is ignored, so it cannot leave redirection suppressed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | AW | Address being fetched this cycle |
| cnt_reg_i | input | CW | Register value offered as a loop count |
| blk_start_i | input | 1 | Block-loop command at pc_i |
| blk_src_reg_i | input | 1 | Block count source: 1 register, 0 immediate |
| blk_imm_i | input | CW | Block count immediate |
| blk_last_i | input | AW | Address of the last body instruction |
| rep_start_i | input | 1 | Repeat command at pc_i |
| rep_src_reg_i | input | 1 | Repeat count source: 1 register, 0 immediate |
| rep_imm_i | input | CW | Repeat count immediate |
| isr_enter_i | input | 1 | Interrupt service entry pulse |
| isr_exit_i | input | 1 | Interrupt service return pulse |
| redirect_o | output | 1 | Next fetch address override valid |
| redirect_pc_o | output | AW | Next fetch address when redirect_o is 1 |
| blk_active_o | output | 1 | Block loop running |
| rep_active_o | output | 1 | Repeat running |
| isr_lock_o | output | 1 | Interrupt entry must be held off |
| nest_err_o | output | 1 | Block start refused because a loop is running |

## Verification
A wrong down-counter or address register shows up as a wrong number of fetches of body addresses. It also shows up as a redirect on the wrong fetch, or as a missing redirect, and this becomes visible by the end of the pass in which the state went wrong. A stuck or leaked interrupt depth shows up on the first fetch of the last address after service returns: that fetch falls through instead of looping back, and the body count comes up short. Interaction faults between repeat and block loop change the fetch count of the shared last instruction within one pass.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic {
    CNT_IMM = 1'b0,
    CNT_REG = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/hwl_cnt_mux.sv
module hwl_cnt_mux
  import hwl_pkg::*;
#(
  parameter int CW = 16
) (
  input  cnt_src_e        src_i,
  input  logic [CW-1:0]   imm_i,
  input  logic [CW-1:0]   reg_i,
  output logic [CW-1:0]   cnt_o
);
  always_comb begin
    unique case (src_i)
      CNT_REG: cnt_o = reg_i;
      default: cnt_o = imm_i;
    endcase
  end
endmodule

// File: rtl/hwl_isr.sv
module hwl_isr #(
  parameter int DW = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic exit_i,
  output logic busy_o
);
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic [DW-1:0] DONE = DW'(1);

  logic [DW-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else if (enter_i && !exit_i) begin
      if (depth_q != DMAX) depth_q <= depth_q + DONE;
    end else if (exit_i && !enter_i) begin
      if (depth_q != '0) depth_q <= depth_q - DONE;
    end
  end

  assign busy_o = (depth_q != '0);

  assert_exit_floor_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && !enter_i && depth_q == '0) |=> (depth_q == '0));
  assert_enter_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && !exit_i) |=> busy_o);
endmodule

// File: rtl/hwl_rep.sv
module hwl_rep #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  output logic          active_o,
  output logic          hold_o,
  output logic [AW-1:0] hold_pc_o,
  output logic          skip_o,
  output logic [AW-1:0] skip_pc_o
);
  localparam logic [AW-1:0] A1 = AW'(1);
  localparam logic [AW-1:0] A2 = AW'(2);
  localparam logic [CW-1:0] C1 = CW'(1);

  logic          active_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          hit, accept;

  assign hit    = active_q && (pc_i == addr_q);
  assign hold_o = hit && (cnt_q > C1);
  assign accept = start_i && !active_q;
  assign skip_o = accept && (cnt_i == '0);

  assign hold_pc_o = addr_q;
  assign skip_pc_o = pc_i + A2;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
    end else if (accept && cnt_i != '0) begin
      active_q <= 1'b1;
      addr_q   <= pc_i + A1;
      cnt_q    <= cnt_i;
    end else if (hold_o) begin
      cnt_q <= cnt_q - C1;
    end else if (hit) begin
      active_q <= 1'b0;
    end
  end

  assert_hold_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> (active_q && cnt_q == $past(cnt_q) - C1));
  assert_live_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));
  assert_last_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !hold_o) |=> !active_q);
endmodule

// File: rtl/hwl_blk.sv
module hwl_blk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] last_i,
  input  logic          suspend_i,
  input  logic          rep_hold_i,
  output logic          active_o,
  output logic          wrap_o,
  output logic [AW-1:0] wrap_pc_o,
  output logic          skip_o,
  output logic [AW-1:0] skip_pc_o,
  output logic          err_o
);
  localparam logic [AW-1:0] A1 = AW'(1);
  localparam logic [CW-1:0] C1 = CW'(1);

  logic          active_q;
  logic [AW-1:0] first_q, last_q;
  logic [CW-1:0] cnt_q;
  logic          hit, accept;

  // end-of-body fetch, ignored in service and while a repeat holds it
  assign hit    = active_q && !suspend_i && !rep_hold_i && (pc_i == last_q);
  assign wrap_o = hit && (cnt_q > C1);
  assign accept = start_i && !active_q;
  assign skip_o = accept && (cnt_i == '0);
  assign err_o  = start_i && active_q;

  assign wrap_pc_o = first_q;
  assign skip_pc_o = last_i + A1;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
      cnt_q    <= '0;
    end else if (accept && cnt_i != '0) begin
      active_q <= 1'b1;
      first_q  <= pc_i + A1;
      last_q   <= last_i;
      cnt_q    <= cnt_i;
    end else if (wrap_o) begin
      cnt_q <= cnt_q - C1;
    end else if (hit) begin
      active_q <= 1'b0;
    end
  end

  assert_live_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));
  assert_wrap_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(cnt_q) - C1));
  assert_refuse_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !hit) |=> (active_q && $stable(first_q) && $stable(last_q) && $stable(cnt_q)));
  assert_frozen_in_isr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && suspend_i) |=> (active_q && $stable(cnt_q) && $stable(last_q)));
  assert_final_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wrap_o) |=> !active_q);
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
  import hwl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic [CW-1:0] cnt_reg_i,
  input  logic          blk_start_i,
  input  logic          blk_src_reg_i,
  input  logic [CW-1:0] blk_imm_i,
  input  logic [AW-1:0] blk_last_i,
  input  logic          rep_start_i,
  input  logic          rep_src_reg_i,
  input  logic [CW-1:0] rep_imm_i,
  input  logic          isr_enter_i,
  input  logic          isr_exit_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          blk_active_o,
  output logic          rep_active_o,
  output logic          isr_lock_o,
  output logic          nest_err_o
);
  localparam int NSRC = 2;  // 0: block, 1: repeat

  logic [NSRC-1:0]         src_w;
  logic [NSRC-1:0][CW-1:0] imm_w, cnt_w;

  assign src_w[0] = blk_src_reg_i;
  assign src_w[1] = rep_src_reg_i;
  assign imm_w[0] = blk_imm_i;
  assign imm_w[1] = rep_imm_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hwl_cnt_mux #(.CW(CW)) u_mux (
      .src_i (cnt_src_e'(src_w[g])),
      .imm_i (imm_w[g]),
      .reg_i (cnt_reg_i),
      .cnt_o (cnt_w[g])
    );
  end

  logic          in_isr;
  logic          rep_hold, rep_skip, blk_wrap, blk_skip;
  logic [AW-1:0] rep_hold_pc, rep_skip_pc, blk_wrap_pc, blk_skip_pc;

  hwl_isr #(.DW(DW)) u_isr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (isr_enter_i),
    .exit_i  (isr_exit_i),
    .busy_o  (in_isr)
  );

  hwl_rep #(.AW(AW), .CW(CW)) u_rep (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_i      (pc_i),
    .start_i   (rep_start_i),
    .cnt_i     (cnt_w[1]),
    .active_o  (rep_active_o),
    .hold_o    (rep_hold),
    .hold_pc_o (rep_hold_pc),
    .skip_o    (rep_skip),
    .skip_pc_o (rep_skip_pc)
  );

  hwl_blk #(.AW(AW), .CW(CW)) u_blk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_i       (pc_i),
    .start_i    (blk_start_i),
    .cnt_i      (cnt_w[0]),
    .last_i     (blk_last_i),
    .suspend_i  (in_isr),
    .rep_hold_i (rep_hold),
    .active_o   (blk_active_o),
    .wrap_o     (blk_wrap),
    .wrap_pc_o  (blk_wrap_pc),
    .skip_o     (blk_skip),
    .skip_pc_o  (blk_skip_pc),
    .err_o      (nest_err_o)
  );

  // repeat hold outranks everything: it pins the fetch on one word
  always_comb begin
    redirect_o    = 1'b1;
    redirect_pc_o = '0;
    if (rep_hold)      redirect_pc_o = rep_hold_pc;
    else if (blk_skip) redirect_pc_o = blk_skip_pc;
    else if (rep_skip) redirect_pc_o = rep_skip_pc;
    else if (blk_wrap) redirect_pc_o = blk_wrap_pc;
    else               redirect_o    = 1'b0;
  end

  assign isr_lock_o = rep_active_o;

  assert_hold_beats_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_hold |-> !blk_wrap);
  assert_no_wrap_in_isr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_isr |-> !blk_wrap);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_active_o && !rep_active_o && !blk_start_i && !rep_start_i) |-> !redirect_o);
endmodule

// File: tb/hwl_ctrl_test.sv
module hwl_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pc_i = '0, cnt_reg_i = '0, blk_imm_i = '0, blk_last_i = '0, rep_imm_i = '0;
  logic        blk_start_i = 0, blk_src_reg_i = 0, rep_start_i = 0, rep_src_reg_i = 0;
  logic        isr_enter_i = 0, isr_exit_i = 0;
  logic        redirect_o, blk_active_o, rep_active_o, isr_lock_o, nest_err_o;
  logic [15:0] redirect_pc_o;

  always #2 clk_i = ~clk_i;

  hwl_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .cnt_reg_i(cnt_reg_i),
    .blk_start_i(blk_start_i), .blk_src_reg_i(blk_src_reg_i), .blk_imm_i(blk_imm_i),
    .blk_last_i(blk_last_i), .rep_start_i(rep_start_i), .rep_src_reg_i(rep_src_reg_i),
    .rep_imm_i(rep_imm_i), .isr_enter_i(isr_enter_i), .isr_exit_i(isr_exit_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .blk_active_o(blk_active_o),
    .rep_active_o(rep_active_o), .isr_lock_o(isr_lock_o), .nest_err_o(nest_err_o)
  );

  int total = 0, bad = 0;
  int visits [256];
  logic [15:0] pc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_passes(input int n, input int m);
    return n * m;
  endfunction

  function automatic int exp_redirs(input int n, input int m);
    // repeat holds (m-1 per pass) plus block wraps (n-1)
    if (n == 0) return 0;
    return n * (m - 1) + (n - 1);
  endfunction

  task automatic clear_visits();
    for (int i = 0; i < 256; i++) visits[i] = 0;
  endtask

  task automatic cyc(output logic r, output logic [15:0] a, output logic e);
    pc_i = pc;
    #1;
    r = redirect_o; a = redirect_pc_o; e = nest_err_o;
    visits[pc[7:0]]++;
    pc = r ? a : pc + 16'd1;
    @(negedge clk_i);
    blk_start_i = 0; rep_start_i = 0; isr_enter_i = 0; isr_exit_i = 0;
  endtask

  task automatic isr_cyc(input logic [15:0] p, input bit en, input bit ex, output logic r);
    pc_i = p; isr_enter_i = en; isr_exit_i = ex;
    #1;
    r = redirect_o;
    @(negedge clk_i);
    isr_enter_i = 0; isr_exit_i = 0;
  endtask

  task automatic walk(input logic [15:0] stop, input logic [15:0] rep_at, input int rep_m,
                      output int redirs);
    logic r, e; logic [15:0] a; int g;
    g = 0; redirs = 0;
    while (pc != stop && g < 3000) begin
      if (pc == rep_at) begin
        rep_start_i = 1; rep_src_reg_i = 0; rep_imm_i = 16'(rep_m);
      end
      cyc(r, a, e);
      if (r) redirs++;
      g++;
    end
    chk(g < 3000, "R2", "walk reached exit", g, 0);
  endtask

  task automatic blk_trial(input int base, input int len, input int n, input bit use_reg);
    logic r, e; logic [15:0] a; int red; string tag;
    tag = use_reg ? "R3" : "R2";
    clear_visits();
    pc = 16'(base);
    blk_start_i = 1; blk_src_reg_i = use_reg; blk_last_i = 16'(base + len);
    if (use_reg) begin cnt_reg_i = 16'(n); blk_imm_i = 16'(n + 7); end
    else begin blk_imm_i = 16'(n); cnt_reg_i = 16'(n + 3); end
    cyc(r, a, e);
    if (n == 0) begin
      chk(r && a == 16'(base + len + 1), "R4", "zero-count skip target", a, base + len + 1);
      chk(!blk_active_o, "R4", "no loop after zero count", blk_active_o, 0);
    end else begin
      chk(!r, "R2", "no redirect on command", r, 0);
    end
    walk(16'(base + len + 1), 16'hFFFF, 0, red);
    for (int k = 1; k <= len; k++)
      chk(visits[base + k] == exp_passes(n, 1), tag, "body fetch count", visits[base + k], n);
    chk(red == exp_redirs(n, 1), "R2", "redirect count", red, exp_redirs(n, 1));
    chk(!blk_active_o, "R5", "inactive after loop", blk_active_o, 0);
  endtask

  task automatic rep_trial(input int base, input int m, input bit use_reg);
    logic r, e; logic [15:0] a; int red;
    clear_visits();
    pc = 16'(base);
    rep_start_i = 1; rep_src_reg_i = use_reg;
    if (use_reg) begin cnt_reg_i = 16'(m); rep_imm_i = 16'(m + 5); end
    else begin rep_imm_i = 16'(m); cnt_reg_i = 16'(m + 2); end
    cyc(r, a, e);
    if (m == 0) begin
      chk(r && a == 16'(base + 2), "R8", "zero repeat skip target", a, base + 2);
    end else begin
      chk(rep_active_o, "R7", "repeat active", rep_active_o, 1);
      chk(isr_lock_o, "R11", "lock during repeat", isr_lock_o, 1);
    end
    walk(16'(base + 2), 16'hFFFF, 0, red);
    chk(visits[base + 1] == m, use_reg ? "R3" : "R7", "repeated fetches", visits[base + 1], m);
    chk(!rep_active_o && !isr_lock_o, "R7", "repeat released", rep_active_o, 0);
  endtask

  task automatic nest_trial(input int base, input int len, input int n, input int m);
    logic r, e; logic [15:0] a; int red;
    clear_visits();
    pc = 16'(base);
    blk_start_i = 1; blk_src_reg_i = 0; blk_imm_i = 16'(n); blk_last_i = 16'(base + len);
    cyc(r, a, e);
    walk(16'(base + len + 1), 16'(base + len - 1), m, red);
    chk(visits[base + len] == exp_passes(n, m), "R9", "last word fetches",
        visits[base + len], exp_passes(n, m));
    chk(visits[base + len - 1] == n, "R9", "repeat command fetches", visits[base + len - 1], n);
    chk(red == exp_redirs(n, m), "R9", "redirect count", red, exp_redirs(n, m));
    chk(!blk_active_o && !rep_active_o, "R9", "both loops done", blk_active_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r, e; logic [15:0] a; int red;
    void'($urandom(32'd4242));
    @(negedge clk_i);
    #1;
    chk(!redirect_o && !blk_active_o && !rep_active_o && !isr_lock_o && !nest_err_o,
        "R1", "reset outputs", {redirect_o, blk_active_o, rep_active_o, isr_lock_o, nest_err_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // directed corners
    blk_trial(10, 3, 0, 0);
    blk_trial(10, 3, 1, 0);
    blk_trial(20, 1, 5, 0);
    blk_trial(30, 4, 200, 1);
    rep_trial(40, 0, 0);
    rep_trial(40, 1, 0);
    rep_trial(50, 6, 1);
    nest_trial(60, 2, 3, 4);
    nest_trial(70, 4, 2, 1);

    // refused second block start (R6)
    clear_visits();
    pc = 16'd80;
    blk_start_i = 1; blk_src_reg_i = 0; blk_imm_i = 16'd3; blk_last_i = 16'd83;
    cyc(r, a, e);
    chk(!e, "R6", "no error on first start", e, 0);
    blk_start_i = 1; blk_imm_i = 16'd9; blk_last_i = 16'd81;
    cyc(r, a, e);
    chk(e, "R6", "nested start flagged", e, 1);
    walk(16'd84, 16'hFFFF, 0, red);
    for (int k = 81; k <= 83; k++)
      chk(visits[k] == 3, "R6", "running loop unchanged", visits[k], 3);

    // interrupt during a block loop (R10, R12)
    clear_visits();
    pc = 16'd100;
    blk_start_i = 1; blk_src_reg_i = 0; blk_imm_i = 16'd4; blk_last_i = 16'd103;
    cyc(r, a, e);
    while (visits[102] < 2) cyc(r, a, e);
    isr_cyc(16'd200, 1, 0, r);
    isr_cyc(16'd103, 0, 0, r);
    chk(!r, "R10", "no redirect in service", r, 0);
    isr_cyc(16'd201, 1, 0, r);
    isr_cyc(16'd202, 0, 1, r);
    isr_cyc(16'd103, 0, 0, r);
    chk(!r, "R10", "no redirect in nested service", r, 0);
    isr_cyc(16'd203, 0, 1, r);
    isr_cyc(16'd204, 0, 1, r);  // extra exit at depth 0
    chk(blk_active_o, "R10", "loop kept through service", blk_active_o, 1);
    walk(16'd104, 16'hFFFF, 0, red);
    for (int k = 101; k <= 103; k++)
      chk(visits[k] == 4, "R12", "loop resumes after service", visits[k], 4);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      int len, n, m, sel;
      sel = int'($urandom % 3);
      len = 1 + int'($urandom % 6);
      n   = int'($urandom % 7);
      m   = int'($urandom % 6);
      if (sel == 0) blk_trial(16 + int'($urandom % 64), len, n, 1'($urandom % 2));
      else if (sel == 1) rep_trial(16 + int'($urandom % 64), m, 1'($urandom % 2));
      else nest_trial(16 + int'($urandom % 64), len + 1, n + 1, m + 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule